// File: doc/BRIEF.md
# Serial Link Input Frame Serializer

This block is the transmit half of a codec's serial link: it packs the codec's status and record data into a 256-bit input frame and shifts that frame out one bit per bit clock on a single data line. The controller marks each frame by raising a frame sync line. The serializer detects that rise and answers on the very next bit clock with the first bit of the frame. It sends the whole frame MSB first and fills every bit that carries nothing with 0.

A frame has a 16-bit tag slot followed by twelve 20-bit slots. The tag slot carries a codec-ready flag and one valid tag per slot. Slot 1 echoes the index of the register being read and carries ten variable-rate slot-request bits. Slot 2 carries the 16-bit read data, left-justified. Slots 3 and 4 carry the left and right record samples. Slots 5 to 12 are always zero.

The block copies all of its slot inputs at the frame boundary, which is the same edge that drives the first bit, and pulses a one-cycle take strobe at that moment. The upstream logic may then change its inputs freely while the frame is shifting. When the frame is over, the line stays low until the next sync rise.

Top module: `ac_in_frame_ser`

## Requirements
- R1: Let sync_i go from low to high after a rising edge of clk_bit. The following falling edge samples it. On the rising edge after that, sdata_o drives frame bit 0 and take_o is high for exactly that one cycle.
- R2: All slot inputs are copied at the edge that drives frame bit 0. Later changes to the inputs do not affect any bit of the frame in progress.
- R3: Frame bits 0..15 form the tag slot, MSB first. Bit 15 is codec_rdy_i. Bits 14 and 13 are sts_vld_i. Bit 12 is rec_l_vld_i. Bit 11 is rec_r_vld_i. Bits 10..0 are 0.
- R4: Frame bits 16..35 form slot 1, MSB first. Bit 19 is 0. Bits 18:12 are sts_idx_i, or 0 when sts_vld_i is low. Bits 11:2 are slot_req_i, sent whatever the value of sts_vld_i. Bits 1:0 are 0.
- R5: Frame bits 36..55 form slot 2, MSB first. Bits 19:4 are sts_dat_i and bits 3:0 are 0. The whole slot is 0 when sts_vld_i is low.
- R6: Frame bits 56..75 form slot 3 and carry rec_l_i. Frame bits 76..95 form slot 4 and carry rec_r_i. Each sample is sent MSB first, followed by 20-SMP_W zeros. A slot is 0 when its valid flag is low.
- R7: Frame bits 96..255 (slots 5 to 12) are 0. After bit 255, sdata_o stays 0 until the next frame start.
- R8: A sync rise in the middle of a frame aborts that frame. The new frame then starts with the R1 timing, using freshly copied inputs.
- R9: While reset is applied, and after reset until the first frame start, sdata_o and take_o are 0.
- R10: Holding sync_i high for longer than a frame starts only one frame. Only a low-to-high change starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock; data launched on rising edge, sync sampled on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller |
| codec_rdy_i | input | 1 | Codec ready flag for tag bit 15 |
| sts_vld_i | input | 1 | Status response valid (slots 1 and 2) |
| sts_idx_i | input | 7 | Register index echoed in slot 1 |
| sts_dat_i | input | 16 | Register read data for slot 2 |
| slot_req_i | input | 10 | Variable-rate slot-request bits for slot 1 |
| rec_l_vld_i | input | 1 | Left record sample valid |
| rec_l_i | input | SMP_W | Left record sample |
| rec_r_vld_i | input | 1 | Right record sample valid |
| rec_r_i | input | SMP_W | Right record sample |
| sdata_o | output | 1 | Serial input-frame data line |
| take_o | output | 1 | One-cycle strobe: slot inputs were copied |

## Verification
The assertions assume that sync_i changes only just after a rising edge of clk_bit. They also assume that sync_i stays low for at least one full cycle between two rises, so every rise is seen by the falling-edge sampler. The bench drives sync_i and all slot inputs one time unit after a rising edge, and keeps sync_i low for many cycles between frames. It changes the slot inputs only before a sync rise or well after the take strobe. The restart and held-sync cases stay inside the same rule: sync_i goes low first, and only then is it raised again.

// File: rtl/ac_in_pkg.sv
package ac_in_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int FRAME_W   = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int IDX_W     = $clog2(FRAME_W);
  localparam int RIDX_W    = 7;
  localparam int RDAT_W    = 16;
  localparam int REQ_W     = 10;
  localparam int USED_SLOTS = 4;

  typedef struct packed {
    logic              rdy;
    logic              sts_vld;
    logic [RIDX_W-1:0] sts_idx;
    logic [RDAT_W-1:0] sts_dat;
    logic [REQ_W-1:0]  req;
    logic              l_vld;
    logic [SLOT_W-1:0] l_smp;
    logic              r_vld;
    logic [SLOT_W-1:0] r_smp;
  } frame_cont_t;
endpackage

// File: rtl/ac_rst_sync.sv
module ac_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/ac_sync_edge.sv
module ac_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic start_o
);
  logic fe_q;
  logic re_q;

  // sync is launched on the rising edge; capture it on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fe_q <= 1'b0;
    else        fe_q <= sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) re_q <= 1'b0;
    else        re_q <= fe_q;
  end

  assign start_o = fe_q & ~re_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R10
endmodule

// File: rtl/ac_frame_pack.sv
module ac_frame_pack
  import ac_in_pkg::*;
(
  input  frame_cont_t          cont_i,
  output logic [FRAME_W-1:0]   frame_o
);
  localparam int PAD_W = SLOT_W * (NUM_SLOTS - USED_SLOTS);

  logic [TAG_W-1:0]  tag_w;
  logic [SLOT_W-1:0] s1_w, s2_w, s3_w, s4_w;

  always_comb begin
    tag_w = '0;
    tag_w[TAG_W-1] = cont_i.rdy;
    tag_w[TAG_W-2] = cont_i.sts_vld;
    tag_w[TAG_W-3] = cont_i.sts_vld;
    tag_w[TAG_W-4] = cont_i.l_vld;
    tag_w[TAG_W-5] = cont_i.r_vld;

    s1_w = {1'b0, (cont_i.sts_vld ? cont_i.sts_idx : {RIDX_W{1'b0}}),
            cont_i.req, {(SLOT_W-1-RIDX_W-REQ_W){1'b0}}};
    s2_w = cont_i.sts_vld ? {cont_i.sts_dat, {(SLOT_W-RDAT_W){1'b0}}} : '0;
    s3_w = cont_i.l_vld ? cont_i.l_smp : '0;
    s4_w = cont_i.r_vld ? cont_i.r_smp : '0;
  end

  assign frame_o = {tag_w, s1_w, s2_w, s3_w, s4_w, {PAD_W{1'b0}}};
endmodule

// File: rtl/ac_bit_shifter.sv
module ac_bit_shifter
  import ac_in_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o,
  output logic               busy_o,
  output logic [IDX_W-1:0]   pos_o
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] tx_order;
  logic               busy_q, busy_n;
  logic [IDX_W-1:0]   pos_q, pos_n;
  logic               bit_q, bit_n;
  logic               step_en;

  // bit p of tx_order is the p-th bit on the line
  for (genvar gi = 0; gi < FRAME_W; gi++) begin : g_rev
    assign tx_order[gi] = frame_i[FRAME_W-1-gi];
  end

  assign step_en = start_i | busy_q;

  always_comb begin
    busy_n = busy_q;
    pos_n  = pos_q;
    bit_n  = 1'b0;
    if (start_i) begin
      busy_n = 1'b1;
      pos_n  = '0;
      bit_n  = tx_order[0];
    end else if (busy_q && pos_q != LAST_POS) begin
      pos_n  = pos_q + 1'b1;
      bit_n  = tx_order[pos_n];
    end else if (busy_q) begin
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      bit_q  <= 1'b0;
    end else if (step_en) begin
      busy_q <= busy_n;
      pos_q  <= pos_n;
      bit_q  <= bit_n;
    end
  end

  assign sdata_o = bit_q;
  assign busy_o  = busy_q;
  assign pos_o   = pos_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sdata_o); // R7
endmodule

// File: rtl/ac_in_frame_ser.sv
module ac_in_frame_ser
  import ac_in_pkg::*;
#(
  parameter int SMP_W = 20
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              codec_rdy_i,
  input  logic              sts_vld_i,
  input  logic [6:0]        sts_idx_i,
  input  logic [15:0]       sts_dat_i,
  input  logic [9:0]        slot_req_i,
  input  logic              rec_l_vld_i,
  input  logic [SMP_W-1:0]  rec_l_i,
  input  logic              rec_r_vld_i,
  input  logic [SMP_W-1:0]  rec_r_i,
  output logic              sdata_o,
  output logic              take_o
);
  localparam int PADS = SLOT_W - SMP_W;
  localparam logic [IDX_W-1:0] S0_PAD_LO = IDX_W'(TAG_W - 11);
  localparam logic [IDX_W-1:0] S2_LO     = IDX_W'(TAG_W + SLOT_W);
  localparam logic [IDX_W-1:0] S2_HI     = IDX_W'(TAG_W + 2 * SLOT_W - 1);
  localparam logic [IDX_W-1:0] ZERO_FROM = IDX_W'(TAG_W + USED_SLOTS * SLOT_W);

  logic               rst_n_s;
  logic               start_w;
  logic [SLOT_W-1:0]  l_just, r_just;
  frame_cont_t        live_w, held_q, held_n, pack_src;
  logic [FRAME_W-1:0] frame_w;
  logic               take_q;
  logic               busy_w;
  logic [IDX_W-1:0]   pos_w;

  ac_rst_sync u_rst (
    .clk     (clk_bit),
    .rst_n_a (rst_n),
    .rst_n_o (rst_n_s)
  );

  ac_sync_edge u_edge (
    .clk     (clk_bit),
    .rst_n   (rst_n_s),
    .sync_i  (sync_i),
    .start_o (start_w)
  );

  // left-justify samples inside the 20-bit slot
  if (PADS == 0) begin : g_full
    assign l_just = rec_l_i;
    assign r_just = rec_r_i;
  end else begin : g_pad
    assign l_just = {rec_l_i, {PADS{1'b0}}};
    assign r_just = {rec_r_i, {PADS{1'b0}}};
  end

  always_comb begin
    live_w.rdy     = codec_rdy_i;
    live_w.sts_vld = sts_vld_i;
    live_w.sts_idx = sts_idx_i;
    live_w.sts_dat = sts_dat_i;
    live_w.req     = slot_req_i;
    live_w.l_vld   = rec_l_vld_i;
    live_w.l_smp   = l_just;
    live_w.r_vld   = rec_r_vld_i;
    live_w.r_smp   = r_just;
    held_n   = start_w ? live_w : held_q;
    pack_src = held_n;
  end

  always_ff @(posedge clk_bit or negedge rst_n_s) begin
    if (!rst_n_s) begin
      held_q <= '0;
      take_q <= 1'b0;
    end else begin
      if (start_w) held_q <= held_n;
      take_q <= start_w;
    end
  end

  ac_frame_pack u_pack (
    .cont_i  (pack_src),
    .frame_o (frame_w)
  );

  ac_bit_shifter u_shift (
    .clk     (clk_bit),
    .rst_n   (rst_n_s),
    .start_i (start_w),
    .frame_i (frame_w),
    .sdata_o (sdata_o),
    .busy_o  (busy_w),
    .pos_o   (pos_w)
  );

  assign take_o = take_q;

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk_bit) disable iff (!rst_n_s)
    take_o |=> !take_o); // R1
  AST_READY_LEADS: assert property (@(posedge clk_bit) disable iff (!rst_n_s)
    take_o |-> (sdata_o == $past(codec_rdy_i))); // R3
  AST_TAG_PAD_ZERO: assert property (@(posedge clk_bit) disable iff (!rst_n_s)
    (busy_w && pos_w >= S0_PAD_LO && pos_w < IDX_W'(TAG_W)) |-> !sdata_o); // R3
  AST_SLOT2_BLANK: assert property (@(posedge clk_bit) disable iff (!rst_n_s)
    (busy_w && !held_q.sts_vld && pos_w >= S2_LO && pos_w <= S2_HI) |-> !sdata_o); // R5
  AST_TAIL_ZERO: assert property (@(posedge clk_bit) disable iff (!rst_n_s)
    (busy_w && pos_w >= ZERO_FROM) |-> !sdata_o); // R7
endmodule

// File: tb/ac_in_frame_ser_bench.sv
module ac_in_frame_ser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SMP_W = 18;
  localparam int FW = 256;

  typedef struct {
    logic b;
    logic t;
    int   pos;
    int   tg;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic sync;
  logic rdy, sv, lv, rv;
  logic [6:0] idx;
  logic [15:0] dat;
  logic [9:0] req;
  logic [SMP_W-1:0] ls, rs;
  logic sdata, take;

  int n_tests = 0;
  int n_fail  = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ac_in_frame_ser #(.SMP_W(SMP_W)) u_ac_in_frame_ser (
    .clk_bit(clk), .rst_n(rst_n), .sync_i(sync),
    .codec_rdy_i(rdy), .sts_vld_i(sv), .sts_idx_i(idx), .sts_dat_i(dat),
    .slot_req_i(req), .rec_l_vld_i(lv), .rec_l_i(ls),
    .rec_r_vld_i(rv), .rec_r_i(rs), .sdata_o(sdata), .take_o(take)
  );

  function automatic string req_name(int pos, int tg);
    if (tg == 2)  return "R2";
    if (tg == 8)  return "R8";
    if (tg == 10) return "R10";
    if (pos < 0)  return "R7";
    if (pos < 16) return "R3";
    if (pos < 36) return "R4";
    if (pos < 56) return "R5";
    if (pos < 96) return "R6";
    return "R7";
  endfunction

  // expected frame from the requirements, first bit at [FW-1]
  function automatic logic [FW-1:0] mk_frame();
    logic [15:0] s0;
    logic [19:0] s1, s2, s3, s4;
    s0 = {rdy, sv, sv, lv, rv, 11'b0};
    s1 = {1'b0, (sv ? idx : 7'b0), req, 2'b00};
    s2 = sv ? {dat, 4'b0000} : 20'b0;
    s3 = lv ? {ls, {(20-SMP_W){1'b0}}} : 20'b0;
    s4 = rv ? {rs, {(20-SMP_W){1'b0}}} : 20'b0;
    return {s0, s1, s2, s3, s4, 160'b0};
  endfunction

  task automatic set_in(logic a_rdy, logic a_sv, logic [6:0] a_idx,
                        logic [15:0] a_dat, logic [9:0] a_req,
                        logic a_lv, logic [SMP_W-1:0] a_l,
                        logic a_rv, logic [SMP_W-1:0] a_r);
    rdy = a_rdy; sv = a_sv; idx = a_idx; dat = a_dat; req = a_req;
    lv = a_lv; ls = a_l; rv = a_rv; rs = a_r;
  endtask

  // raise sync, queue the expected frame, drop sync after hold cycles
  task automatic launch(int hold, int idle, int tg);
    logic [FW-1:0] f;
    f = mk_frame();
    @(posedge clk); #1 sync = 1'b1;
    @(negedge clk); #1;
    q.delete();
    for (int p = 0; p < FW; p++)
      q.push_back('{b: f[FW-1-p], t: (p == 0), pos: p, tg: tg});
    for (int k = 0; k < idle; k++)
      q.push_back('{b: 1'b0, t: 1'b0, pos: -1, tg: tg});
    repeat (hold) @(posedge clk);
    #1 sync = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    #1;
  endtask

  // monitor: pop one expected item per cycle, away from the launch edge
  always @(negedge clk) begin
    if (rst_n && q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      n_tests++;
      if (sdata !== it.b) begin
        n_fail++;
        $display("FAIL %s pos=%0d sdata actual=%0b expected=%0b",
                 req_name(it.pos, it.tg), it.pos, sdata, it.b);
      end
      n_tests++;
      if (take !== it.t) begin
        n_fail++;
        $display("FAIL R1 pos=%0d take actual=%0b expected=%0b",
                 it.pos, take, it.t);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sync  = 1'b0;
    set_in(1, 1, 7'h55, 16'hA5C3, 10'h2AB, 1, 18'h2F0F1, 1, 18'h1ABCD);
    repeat (4) @(negedge clk);
    n_tests++;
    if (sdata !== 1'b0 || take !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 in reset actual=%0b%0b expected=00", sdata, take);
    end
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    n_tests++;
    if (sdata !== 1'b0 || take !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 after reset actual=%0b%0b expected=00", sdata, take);
    end
    #1;

    // all slots valid
    launch(16, 20, 0);
    drain();

    // status invalid: R4 index blanked, R5 slot zero; right invalid
    set_in(1, 0, 7'h7F, 16'hFFFF, 10'h3FF, 1, 18'h3FFFF, 0, 18'h3FFFF);
    launch(16, 12, 0);
    drain();

    // not ready, nothing valid, request bits still sent (R4)
    set_in(0, 0, 7'h12, 16'h1234, 10'h201, 0, 18'h00001, 0, 18'h20000);
    launch(16, 12, 0);
    drain();

    // R2: inputs change while the frame shifts
    set_in(1, 1, 7'h2A, 16'h8001, 10'h155, 1, 18'h20001, 1, 18'h3C3C3);
    launch(16, 12, 2);
    set_in(0, 0, 7'h55, 16'h7FFE, 10'h2AA, 0, 18'h1FFFE, 0, 18'h03C3C);
    drain();

    // R8: restart in the middle of a frame
    set_in(1, 1, 7'h01, 16'hF00F, 10'h0F0, 1, 18'h12345, 1, 18'h2AAAA);
    launch(16, 20, 0);
    repeat (60) @(posedge clk);
    #1 set_in(1, 1, 7'h40, 16'h0FF0, 10'h30C, 1, 18'h15555, 0, 18'h0);
    launch(16, 20, 8);
    drain();

    // R10: sync held high past the end of the frame
    set_in(1, 0, 7'h33, 16'hBEEF, 10'h111, 1, 18'h0AAAA, 1, 18'h35555);
    launch(300, 80, 10);
    drain();

    // R6: extreme sample values show the trailing zero pad
    set_in(1, 1, 7'h7F, 16'hFFFF, 10'h3FF, 1, 18'h3FFFF, 1, 18'h20000);
    launch(16, 12, 0);
    drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule